// File: doc/BRIEF.md
# Triggered SAR Converter Control Logic

This block is the digital sequencer of a single-channel successive-approximation converter. A high-to-low transition on the convert-start input turns on the analog section and starts a timed run. The run is an acquisition window followed by one bit trial per timebase tick. During the trials the block drives a trial code to the capacitive DAC and reads back a one-bit comparator decision. An input selector picks either the external channel or a mid-supply self-test level. The self-test level is chosen when a second start strobe arrives during a run, and that strobe also restarts the run.

When the last bit is decided, the analog enable drops. The result is loaded into an output shift register, and its MSB appears at once on the serial data output. An external serial clock then moves the remaining bits out. The serial clock is ignored while a conversion is running. The data output is modelled as a data bit plus an output-enable, and it floats after the eighth rising clock edge. Both idle levels of the serial clock are supported.

FSM states: `ST_OFF` (shut down, output floating), `ST_ACQ` (acquisition), `ST_CONV` (bit trials), `ST_READ` (result shifting out). Transitions:
- OFF→ACQ and READ→ACQ on a start edge, selecting the external channel.
- ACQ→ACQ and CONV→ACQ on a start edge, as an abort that restarts on the mid-supply level.
- ACQ→CONV after `ACQ_TICKS` ticks.
- CONV→READ on the final trial.
- READ→OFF on the eighth rising serial clock edge.

Top module: `sar_trig_ctrl`

## Requirements
- R1: A conversion, with `ana_en_o`=1, starts only on a high-to-low transition of `cnv_start_i` seen after reset. Leaving reset with `cnv_start_i` already low starts nothing.
- R2: A start edge during acquisition or trials restarts the sequence from acquisition with `mux_mid_o`=1 (mid-supply selected). The interrupted run loads no result.
- R3: When a start edge falls in the same cycle as the final bit trial, the abort wins. The block stays converting, with `mux_mid_o`=1 and the data output driven low.
- R4: While converting, `sdo_oe_o`=1 and `sdo_o`=0.
- R5: The sequence ends exactly `(ACQ_TICKS+RES_BITS)*DIV_CYC` clock cycles after the start edge, and never later than `MAX_CONV_CYC`. At that point `ana_en_o` drops and `sdo_o` shows the result MSB.
- R6: Bit trials run MSB first. The first trial code is 0x80. `cmp_i`=1 keeps the trial bit, so the result is the straight-binary value of the sampled level.
- R7: Serial clock edges during a conversion have no effect on the later readout.
- R8: Data changes only on a serial-clock falling edge that follows a rising edge. It goes out MSB first, for clocks idling either low or high.
- R9: After the eighth rising serial clock edge of a readout, `sdo_oe_o`=0.
- R10: A start edge in the shutdown or readout state begins a conversion on the external channel (`mux_mid_o`=0).
- R11: During reset, `ana_en_o`=0, `sdo_oe_o`=0 and `mux_mid_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnv_start_i | input | 1 | Convert-start strobe; a falling edge is the trigger |
| sclk_i | input | 1 | External serial clock |
| cmp_i | input | 1 | Comparator decision: 1 = input at or above trial code |
| dac_code_o | output | RES_BITS | Trial code for the capacitive DAC |
| mux_mid_o | output | 1 | 1 selects the mid-supply test level, 0 the external channel |
| ana_en_o | output | 1 | Power enable for the analog section |
| sdo_o | output | 1 | Serial data bit |
| sdo_oe_o | output | 1 | Serial data output enable (0 = high impedance) |

## Verification
Completion of the final bit trial and an abort strobe can land on the same clock edge. The bench provokes this by taking the strobe high two cycles early and dropping it so the falling edge is sampled on exactly the cycle of the last tick. It judges the outcome by checking that `ana_en_o` and the drive-low state remain and that the mid-supply input is selected. The restarted run must then read out 0x80, not the channel value. Serial clock toggling during a run is also checked, since it must neither shift nor count toward the eight readout edges.

// File: rtl/sar_trig_pkg.sv
package sar_trig_pkg;
    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_ACQ  = 2'd1,
        ST_CONV = 2'd2,
        ST_READ = 2'd3
    } conv_state_e;
endpackage

// File: rtl/sar_edge_det.sv
module sar_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_i,
    output logic rise_o,
    output logic fall_o
);
    logic sig_q;

    always_ff @(posedge clk) begin
        if (!rst_n) sig_q <= 1'b0;
        else        sig_q <= sig_i;
    end

    assign rise_o = sig_i & ~sig_q;
    assign fall_o = sig_q & ~sig_i;
endmodule

// File: rtl/sar_timebase.sv
module sar_timebase #(
    parameter int DIV_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic run_i,
    output logic tick_o
);
    localparam int CW = (DIV_CYC > 1) ? $clog2(DIV_CYC) : 1;
    logic [CW-1:0] cnt_q;

    assign tick_o = run_i && (cnt_q == CW'(DIV_CYC - 1));

    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) cnt_q <= '0;
        else if (run_i)      cnt_q <= tick_o ? '0 : cnt_q + 1'b1;
    end
endmodule

// File: rtl/sar_approx.sv
module sar_approx #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         init_i,
    input  logic         step_i,
    input  logic         cmp_i,
    output logic [W-1:0] trial_o,
    output logic [W-1:0] result_o,
    output logic         last_o
);
    localparam int IW = (W > 1) ? $clog2(W) : 1;
    logic [W-1:0]  code_q;
    logic [IW-1:0] idx_q;
    logic [W-1:0]  probe;

    assign probe    = {{(W-1){1'b0}}, 1'b1} << idx_q;
    assign trial_o  = code_q | probe;
    assign result_o = cmp_i ? trial_o : code_q;
    assign last_o   = (idx_q == '0);

    always_ff @(posedge clk) begin
        if (!rst_n || init_i) begin
            code_q <= '0;
            idx_q  <= IW'(W - 1);
        end else if (step_i) begin
            code_q <= result_o;
            idx_q  <= last_o ? IW'(W - 1) : idx_q - 1'b1;
        end
    end
endmodule

// File: rtl/sar_shift_out.sv
module sar_shift_out #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] data_i,
    input  logic         en_i,
    input  logic         rise_i,
    input  logic         fall_i,
    output logic         bit_o,
    output logic         done_o
);
    localparam int RW = $clog2(W + 1);
    logic [W-1:0]  sh_q;
    logic [RW-1:0] rcnt_q;
    logic          armed_q;

    assign bit_o  = sh_q[W-1];
    assign done_o = en_i && rise_i && (rcnt_q == RW'(W - 1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q    <= '0;
            rcnt_q  <= '0;
            armed_q <= 1'b0;
        end else if (load_i) begin
            sh_q    <= data_i;
            rcnt_q  <= '0;
            armed_q <= 1'b0;
        end else if (en_i) begin
            if (rise_i) begin
                armed_q <= 1'b1;
                rcnt_q  <= rcnt_q + 1'b1;
            end else if (fall_i && armed_q) begin
                armed_q <= 1'b0;
                sh_q    <= {sh_q[W-2:0], 1'b0};
            end
        end
    end
endmodule

// File: rtl/sar_trig_ctrl.sv
module sar_trig_ctrl
    import sar_trig_pkg::*;
#(
    parameter int RES_BITS     = 8,
    parameter int DIV_CYC      = 4,
    parameter int ACQ_TICKS    = 2,
    parameter int MAX_CONV_CYC = 1500
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cnv_start_i,
    input  logic                sclk_i,
    input  logic                cmp_i,
    output logic [RES_BITS-1:0] dac_code_o,
    output logic                mux_mid_o,
    output logic                ana_en_o,
    output logic                sdo_o,
    output logic                sdo_oe_o
);
    localparam int AW = (ACQ_TICKS > 1) ? $clog2(ACQ_TICKS) : 1;

    conv_state_e         state_q, state_d;
    logic [AW-1:0]       acq_q, acq_d;
    logic                mid_q, mid_d;
    logic                cnv_fall, cnv_rise_nc;
    logic                sclk_rise, sclk_fall;
    logic                tick, tb_clr, tb_run;
    logic                sar_init, sar_step, sar_last;
    logic [RES_BITS-1:0] sar_result;
    logic                sh_load, sh_bit, sh_done;

    sar_edge_det u_cnv_edge (
        .clk(clk), .rst_n(rst_n), .sig_i(cnv_start_i),
        .rise_o(cnv_rise_nc), .fall_o(cnv_fall)
    );

    sar_edge_det u_sclk_edge (
        .clk(clk), .rst_n(rst_n), .sig_i(sclk_i),
        .rise_o(sclk_rise), .fall_o(sclk_fall)
    );

    sar_timebase #(.DIV_CYC(DIV_CYC)) u_tb (
        .clk(clk), .rst_n(rst_n), .clr_i(tb_clr), .run_i(tb_run), .tick_o(tick)
    );

    sar_approx #(.W(RES_BITS)) u_sar (
        .clk(clk), .rst_n(rst_n), .init_i(sar_init), .step_i(sar_step),
        .cmp_i(cmp_i), .trial_o(dac_code_o), .result_o(sar_result),
        .last_o(sar_last)
    );

    sar_shift_out #(.W(RES_BITS)) u_sh (
        .clk(clk), .rst_n(rst_n), .load_i(sh_load), .data_i(sar_result),
        .en_i(state_q == ST_READ), .rise_i(sclk_rise), .fall_i(sclk_fall),
        .bit_o(sh_bit), .done_o(sh_done)
    );

    assign tb_run = (state_q == ST_ACQ) || (state_q == ST_CONV);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
            acq_q   <= '0;
            mid_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            acq_q   <= acq_d;
            mid_q   <= mid_d;
        end
    end

    // Next-state logic; an abort strobe takes priority over a completing tick
    always_comb begin
        state_d  = state_q;
        acq_d    = acq_q;
        mid_d    = mid_q;
        tb_clr   = 1'b0;
        sar_init = 1'b0;
        sar_step = 1'b0;
        sh_load  = 1'b0;
        unique case (state_q)
            ST_OFF, ST_READ: begin
                if (cnv_fall) begin
                    state_d = ST_ACQ;
                    mid_d   = 1'b0;
                    acq_d   = '0;
                    tb_clr  = 1'b1;
                end else if (state_q == ST_READ && sh_done) begin
                    state_d = ST_OFF;
                end
            end
            ST_ACQ, ST_CONV: begin
                if (cnv_fall) begin
                    state_d = ST_ACQ;
                    mid_d   = 1'b1;
                    acq_d   = '0;
                    tb_clr  = 1'b1;
                end else if (tick) begin
                    if (state_q == ST_ACQ) begin
                        if (acq_q == AW'(ACQ_TICKS - 1)) begin
                            state_d  = ST_CONV;
                            sar_init = 1'b1;
                        end else begin
                            acq_d = acq_q + 1'b1;
                        end
                    end else begin
                        sar_step = 1'b1;
                        if (sar_last) begin
                            sh_load = 1'b1;
                            state_d = ST_READ;
                        end
                    end
                end
            end
        endcase
    end

    // Outputs
    always_comb begin
        ana_en_o  = tb_run;
        sdo_oe_o  = tb_run || (state_q == ST_READ);
        sdo_o     = (state_q == ST_READ) ? sh_bit : 1'b0;
        mux_mid_o = mid_q;
    end
endmodule

// File: rtl/sar_trig_ctrl_chk.sv
module sar_trig_ctrl_chk #(
    parameter int MAX_CONV_CYC = 1500
) (
    input logic clk,
    input logic rst_n,
    input logic cnv_start_i,
    input logic sclk_i,
    input logic mux_mid_o,
    input logic ana_en_o,
    input logic sdo_o,
    input logic sdo_oe_o
);
    logic        seen_q;
    logic        cnv_prev_q;
    logic [31:0] run_cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_q     <= 1'b0;
            cnv_prev_q <= 1'b0;
            run_cnt_q  <= '0;
        end else begin
            seen_q     <= 1'b1;
            cnv_prev_q <= cnv_start_i;
            if (!ana_en_o || (cnv_prev_q && !cnv_start_i)) run_cnt_q <= '0;
            else                                            run_cnt_q <= run_cnt_q + 1;
        end
    end

    assert_start_on_fall_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && $fell(cnv_start_i)) |=> ana_en_o);

    assert_mid_only_on_abort_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mux_mid_o) |-> (ana_en_o && $past(ana_en_o)));

    assert_drive_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ana_en_o |-> (sdo_oe_o && !sdo_o));

    assert_conv_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        run_cnt_q <= MAX_CONV_CYC);

    assert_done_presents_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ana_en_o) |-> sdo_oe_o);

    assert_shift_on_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (sdo_oe_o && !ana_en_o && !$fell(sclk_i))
        |=> ($stable(sdo_o) || !sdo_oe_o || ana_en_o));

    assert_float_from_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sdo_oe_o) |-> !ana_en_o);

    assert_channel_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ana_en_o) |-> !mux_mid_o);
endmodule

bind sar_trig_ctrl sar_trig_ctrl_chk #(.MAX_CONV_CYC(MAX_CONV_CYC)) chk_i (
    .clk(clk), .rst_n(rst_n), .cnv_start_i(cnv_start_i), .sclk_i(sclk_i),
    .mux_mid_o(mux_mid_o), .ana_en_o(ana_en_o), .sdo_o(sdo_o), .sdo_oe_o(sdo_oe_o)
);

// File: tb/sar_trig_ctrl_tb_top.sv
module sar_trig_ctrl_tb_top;
    localparam int W        = 8;
    localparam int DIV      = 4;
    localparam int ACQ      = 2;
    localparam int CONV_CYC = (ACQ + W) * DIV;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cnv = 1'b0;
    logic         sclk = 1'b0;
    logic         cmp;
    logic [W-1:0] dac;
    logic         mid, ana_en, sdo, sdo_oe;
    logic [W-1:0] ain = '0;
    int           n_chk = 0;
    int           n_fail = 0;
    bit           finished = 1'b0;

    always #2.5 clk = ~clk;

    // Comparator model: mid-supply level is code 0x80
    assign cmp = ((mid ? 8'h80 : ain) >= dac);

    sar_trig_ctrl #(.RES_BITS(W), .DIV_CYC(DIV), .ACQ_TICKS(ACQ), .MAX_CONV_CYC(1500)) dut_i (
        .clk(clk), .rst_n(rst_n), .cnv_start_i(cnv), .sclk_i(sclk), .cmp_i(cmp),
        .dac_code_o(dac), .mux_mid_o(mid), .ana_en_o(ana_en), .sdo_o(sdo), .sdo_oe_o(sdo_oe)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_n(input int k);
        repeat (k) @(negedge clk);
    endtask

    task automatic t_reset();
        rst_n = 1'b0; cnv = 1'b0; sclk = 1'b0;
        wait_n(5);
        check("R11 ana_en in reset", ana_en, 0);
        check("R11 oe in reset", sdo_oe, 0);
        check("R11 mid in reset", mid, 0);
        rst_n = 1'b1;
        wait_n(12);
        check("R1 no start with strobe low from reset", ana_en, 0);
        check("R1 output floats", sdo_oe, 0);
    endtask

    task automatic read_word(input logic [W-1:0] exp, input bit idle_high);
        if (idle_high) begin
            sclk = 1'b0; wait_n(2);
            check("R8 leading fall does not shift", sdo, exp[W-1]);
        end
        for (int k = 0; k < W; k++) begin
            check("R8 data bit MSB first", sdo, exp[W-1-k]);
            sclk = 1'b1; wait_n(2);
            if (k == W - 1) begin
                check("R9 float after eighth rise", sdo_oe, 0);
            end else begin
                check("R8 rise does not change data", sdo, exp[W-1-k]);
                check("R9 still driven", sdo_oe, 1);
            end
            if (k < W - 1 || !idle_high) begin
                sclk = 1'b0; wait_n(2);
            end
        end
    endtask

    // Start strobe, wait for completion; returns cycles counted to completion
    task automatic run_to_done(input bit noise, input bit exp_mid, output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
            if (noise && n < 31) sclk = ~sclk;
            if (n == 1) begin
                check("R4 output low while converting", {sdo_oe, sdo}, 2'b10);
                check("R10/R2 input select", mid, exp_mid);
            end
            if (n == ACQ * DIV + 2)
                check("R6 first trial code", dac, 8'h80);
        end while (ana_en && n < 200);
    endtask

    task automatic t_convert(input logic [W-1:0] v, input bit idle_high, input bit noise);
        int n;
        ain = v; sclk = idle_high;
        cnv = 1'b1; wait_n(2);
        cnv = 1'b0;
        run_to_done(noise, 1'b0, n);
        check("R5 completion cycle", n - 1, CONV_CYC);
        check("R5 MSB presented", {sdo_oe, sdo}, {1'b1, v[W-1]});
        check("R7 clock ignored, still driven", sdo_oe, 1);
        read_word(v, idle_high);
        check("R6 mux stays external", mid, 0);
    endtask

    task automatic t_abort(input logic [W-1:0] v);
        int n;
        ain = v; sclk = 1'b0;
        cnv = 1'b1; wait_n(2);
        cnv = 1'b0; wait_n(10);
        check("R2 channel before abort", mid, 0);
        cnv = 1'b1; wait_n(2);
        cnv = 1'b0;
        run_to_done(1'b0, 1'b1, n);
        check("R2 restart timing", n - 1, CONV_CYC);
        read_word(8'h80, 1'b0);
    endtask

    task automatic t_collide(input logic [W-1:0] v);
        int n;
        ain = v; sclk = 1'b0;
        cnv = 1'b1; wait_n(2);
        cnv = 1'b0;
        wait_n(CONV_CYC - 2);
        cnv = 1'b1; wait_n(2);
        cnv = 1'b0; wait_n(1);
        check("R3 abort wins over completion", ana_en, 1);
        check("R3 output held low", {sdo_oe, sdo}, 2'b10);
        check("R3 mid selected", mid, 1);
        run_to_done(1'b0, 1'b1, n);
        check("R3 restarted run length", n, CONV_CYC);
        read_word(8'h80, 1'b0);
    endtask

    initial begin
        t_reset();
        t_convert(8'hA5, 1'b0, 1'b1);
        t_convert(8'h3C, 1'b1, 1'b1);
        t_convert(8'h00, 1'b0, 1'b0);
        t_convert(8'hFF, 1'b1, 1'b0);
        t_abort(8'hE7);
        t_convert(8'h5A, 1'b0, 1'b0);
        t_collide(8'hC5);
        t_convert(8'h01, 1'b0, 1'b1);
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end
endmodule